// File: doc/BRIEF.md
# Priority Address Range Decoder

This block maps one request address onto a target port index using a table of address windows supplied at run time. Each table entry gives a lower bound, an upper bound and the port it points at. The lower bound is part of the window and the upper bound is not. Windows may overlap. When more than one window contains the address, the entry with the largest table index decides the target. Several entries may name the same port.

When no window contains the address, a switchable fallback takes over. If the fallback is enabled, the request goes to a supplied fallback port. If it is disabled, the block raises a decode-error flag, so the request can be handed to an error responder. The block is purely combinational, and its outputs follow the inputs in the same cycle.

The table and the fallback settings are assumed to stay still while a request is presented. Two variants of the priority selection are available through a parameter: a linear scan and a balanced binary tree. Both give the same results.

Top module: `adr_range_decoder`

## Requirements
- R1: An entry whose lower bound is less than or equal to its upper bound matches an address equal to its lower bound, and does not match an address one below it.
- R2: An entry does not match an address equal to its upper bound, and does match the address one below its upper bound. This holds even when the upper bound is the largest value the address can take.
- R3: An entry whose lower and upper bounds are equal matches no address.
- R4: When several entries contain the address, `tgt_o` takes the port index of the matching entry with the largest table index.
- R5: Two or more entries may name the same port, and each of them routes to that port. `tgt_o` stays below the port count whenever `valid_o` is 1.
- R6: With a request present, no entry matching and `dflt_en_i` = 1, the outputs are `valid_o` = 1, `dec_err_o` = 0 and `tgt_o` = `dflt_tgt_i`.
- R7: With a request present, no entry matching and `dflt_en_i` = 0, the outputs are `dec_err_o` = 1, `valid_o` = 0 and `tgt_o` = 0.
- R8: While `req_valid_i` = 0, all three outputs (`valid_o`, `dec_err_o`, `tgt_o`) are 0, whatever the address and the table hold.
- R9: While `req_valid_i` = 1, exactly one of `valid_o` and `dec_err_o` is 1.
- R10: The linear-scan and tree variants produce identical outputs for identical inputs.
- R11: A matching entry takes precedence over the fallback port, even when `dflt_en_i` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_valid_i | input | 1 | A request address is being presented |
| addr_i | input | ADDR_W | Request address |
| rule_lo_i | input | N_RULES x ADDR_W | Lower bound of each entry (included in the window) |
| rule_hi_i | input | N_RULES x ADDR_W | Upper bound of each entry (excluded from the window) |
| rule_tgt_i | input | N_RULES x TGT_W | Port index of each entry |
| dflt_en_i | input | 1 | Enables the fallback port on a miss |
| dflt_tgt_i | input | TGT_W | Fallback port index |
| valid_o | output | 1 | A target was selected |
| dec_err_o | output | 1 | Miss with the fallback disabled |
| tgt_o | output | TGT_W | Selected port index |

## Verification
The bench probes the two bounds of a window one address apart on each side. A design that used a closed upper bound would route the upper-bound address, and one that used an open lower bound would drop the first address. It stacks three and then four overlapping windows, so that a design resolving overlaps by lowest index or by first match would report the wrong port. Degenerate windows and a window that ends at the largest address are applied. So are a miss with the fallback enabled and one with it disabled, and a hit with the fallback enabled, where a design that let the fallback override a hit would be exposed. Both priority variants are driven by the same stimulus, so a tree that orders its children wrongly or pads its unused leaves wrongly differs from the scan.

// File: rtl/adr_dec_pkg.sv
package adr_dec_pkg;

    localparam int unsigned MAX_ADDR_W = 64;

    typedef enum logic {
        PRIO_LINEAR = 1'b0,
        PRIO_TREE   = 1'b1
    } prio_arch_e;

    // Index width for a count of items, never below one bit.
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Half-open window test on zero-extended operands.
    function automatic logic in_window(input logic [MAX_ADDR_W-1:0] a,
                                       input logic [MAX_ADDR_W-1:0] lo,
                                       input logic [MAX_ADDR_W-1:0] hi);
        return (a >= lo) && (a < hi);
    endfunction

endpackage

// File: rtl/adr_rule_match.sv
module adr_rule_match
    import adr_dec_pkg::*;
#(
    parameter int unsigned N_RULES = 4,
    parameter int unsigned ADDR_W  = 32
) (
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [N_RULES-1:0][ADDR_W-1:0] lo_i,
    input  logic [N_RULES-1:0][ADDR_W-1:0] hi_i,
    output logic [N_RULES-1:0]             hit_o
);

    for (genvar g = 0; g < N_RULES; g++) begin : g_cmp
        assign hit_o[g] = in_window(MAX_ADDR_W'(addr_i),
                                    MAX_ADDR_W'(lo_i[g]),
                                    MAX_ADDR_W'(hi_i[g]));
    end

endmodule

// File: rtl/adr_prio_pick.sv
module adr_prio_pick
    import adr_dec_pkg::*;
#(
    parameter int unsigned N_RULES = 4,
    parameter int unsigned TGT_W   = 3,
    parameter prio_arch_e  ARCH    = PRIO_LINEAR
) (
    input  logic [N_RULES-1:0]            hit_i,
    input  logic [N_RULES-1:0][TGT_W-1:0] tgt_i,
    output logic                          any_o,
    output logic [TGT_W-1:0]              tgt_o
);

    if (ARCH == PRIO_LINEAR) begin : g_linear
        // Later entries overwrite earlier ones: the highest index wins.
        always_comb begin
            any_o = 1'b0;
            tgt_o = '0;
            for (int i = 0; i < N_RULES; i++) begin
                if (hit_i[i]) begin
                    any_o = 1'b1;
                    tgt_o = tgt_i[i];
                end
            end
        end
    end else begin : g_tree
        localparam int unsigned LVLS   = idx_w(N_RULES);
        localparam int unsigned LEAVES = 1 << LVLS;
        localparam int unsigned NODES  = 2 * LEAVES - 1;

        logic             nv [NODES];
        logic [TGT_W-1:0] nt [NODES];

        for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
            if (j < N_RULES) begin : g_used
                assign nv[LEAVES-1+j] = hit_i[j];
                assign nt[LEAVES-1+j] = tgt_i[j];
            end else begin : g_pad
                assign nv[LEAVES-1+j] = 1'b0;
                assign nt[LEAVES-1+j] = '0;
            end
        end

        // Node k: left child 2k+1 (lower indices), right child 2k+2 (higher).
        for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
            assign nv[k] = nv[2*k+1] | nv[2*k+2];
            assign nt[k] = nv[2*k+2] ? nt[2*k+2] :
                           (nv[2*k+1] ? nt[2*k+1] : '0);
        end

        assign any_o = nv[0];
        assign tgt_o = nt[0];
    end

endmodule

// File: rtl/adr_miss_fallback.sv
module adr_miss_fallback #(
    parameter int unsigned TGT_W = 3
) (
    input  logic             req_i,
    input  logic             any_i,
    input  logic [TGT_W-1:0] rule_tgt_i,
    input  logic             dflt_en_i,
    input  logic [TGT_W-1:0] dflt_tgt_i,
    output logic             valid_o,
    output logic             err_o,
    output logic [TGT_W-1:0] tgt_o
);

    always_comb begin
        valid_o = 1'b0;
        err_o   = 1'b0;
        tgt_o   = '0;
        if (req_i) begin
            if (any_i) begin
                valid_o = 1'b1;
                tgt_o   = rule_tgt_i;
            end else if (dflt_en_i) begin
                valid_o = 1'b1;
                tgt_o   = dflt_tgt_i;
            end else begin
                err_o   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/adr_range_decoder.sv
module adr_range_decoder
    import adr_dec_pkg::*;
#(
    parameter int unsigned N_RULES = 4,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned N_PORTS = 5,
    parameter prio_arch_e  ARCH    = PRIO_LINEAR,
    localparam int unsigned TGT_W  = idx_w(N_PORTS)
) (
    input  logic                          req_valid_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [N_RULES-1:0][ADDR_W-1:0] rule_lo_i,
    input  logic [N_RULES-1:0][ADDR_W-1:0] rule_hi_i,
    input  logic [N_RULES-1:0][TGT_W-1:0] rule_tgt_i,
    input  logic                          dflt_en_i,
    input  logic [TGT_W-1:0]              dflt_tgt_i,
    output logic                          valid_o,
    output logic                          dec_err_o,
    output logic [TGT_W-1:0]              tgt_o
);

    logic [N_RULES-1:0] hit;
    logic               any_hit;
    logic [TGT_W-1:0]   rule_tgt;

    adr_rule_match #(
        .N_RULES (N_RULES),
        .ADDR_W  (ADDR_W)
    ) u_match (
        .addr_i (addr_i),
        .lo_i   (rule_lo_i),
        .hi_i   (rule_hi_i),
        .hit_o  (hit)
    );

    adr_prio_pick #(
        .N_RULES (N_RULES),
        .TGT_W   (TGT_W),
        .ARCH    (ARCH)
    ) u_pick (
        .hit_i (hit),
        .tgt_i (rule_tgt_i),
        .any_o (any_hit),
        .tgt_o (rule_tgt)
    );

    adr_miss_fallback #(
        .TGT_W (TGT_W)
    ) u_fallback (
        .req_i      (req_valid_i),
        .any_i      (any_hit),
        .rule_tgt_i (rule_tgt),
        .dflt_en_i  (dflt_en_i),
        .dflt_tgt_i (dflt_tgt_i),
        .valid_o    (valid_o),
        .err_o      (dec_err_o),
        .tgt_o      (tgt_o)
    );

endmodule

// File: rtl/adr_range_decoder_chk.sv
module adr_range_decoder_chk #(
    parameter int unsigned N_RULES = 4,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned N_PORTS = 5,
    parameter int unsigned TGT_W   = 3
) (
    input logic                           req_valid_i,
    input logic [N_RULES-1:0][ADDR_W-1:0] rule_lo_i,
    input logic [N_RULES-1:0][ADDR_W-1:0] rule_hi_i,
    input logic                           dflt_en_i,
    input logic                           valid_o,
    input logic                           dec_err_o,
    input logic [TGT_W-1:0]               tgt_o
);

    always_comb begin
        if (req_valid_i) begin
            for (int i = 0; i < N_RULES; i++) begin
                // R1
                rule_order_chk: assert (rule_lo_i[i] <= rule_hi_i[i])
                    else $error("entry %0d has lower bound above upper bound", i);
            end
            // R9
            one_outcome_chk: assert (valid_o ^ dec_err_o)
                else $error("request must yield exactly one of valid and error");
            // R6
            dflt_no_err_chk: assert (!(dflt_en_i && dec_err_o))
                else $error("error flagged while fallback enabled");
        end else begin
            // R8
            idle_quiet_chk: assert (!valid_o && !dec_err_o && tgt_o == '0)
                else $error("outputs active without a request");
        end
        // R7
        err_tgt_zero_chk: assert (!dec_err_o || tgt_o == '0)
            else $error("target not zero on decode error");
        // R5
        tgt_range_chk: assert (!valid_o || 32'(tgt_o) < N_PORTS || !req_valid_i)
            else $error("target index beyond port count");
    end

endmodule

bind adr_range_decoder adr_range_decoder_chk #(
    .N_RULES (N_RULES),
    .ADDR_W  (ADDR_W),
    .N_PORTS (N_PORTS),
    .TGT_W   (TGT_W)
) u_chk (
    .req_valid_i (req_valid_i),
    .rule_lo_i   (rule_lo_i),
    .rule_hi_i   (rule_hi_i),
    .dflt_en_i   (dflt_en_i),
    .valid_o     (valid_o),
    .dec_err_o   (dec_err_o),
    .tgt_o       (tgt_o)
);

// File: tb/sim_adr_range_decoder.sv
module sim_adr_range_decoder;
    import adr_dec_pkg::*;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned NR = 5;
    localparam int unsigned AW = 16;
    localparam int unsigned NP = 5;
    localparam int unsigned TW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic                       req;
    logic [AW-1:0]              addr;
    logic [NR-1:0][AW-1:0]      lo, hi;
    logic [NR-1:0][TW-1:0]      tg;
    logic                       den;
    logic [TW-1:0]              dtg;
    logic                       v0, e0, v1, e1;
    logic [TW-1:0]              t0, t1;

    int checks = 0;
    int errors = 0;

    adr_range_decoder #(.N_RULES(NR), .ADDR_W(AW), .N_PORTS(NP), .ARCH(PRIO_LINEAR)) u0 (
        .req_valid_i(req), .addr_i(addr), .rule_lo_i(lo), .rule_hi_i(hi),
        .rule_tgt_i(tg), .dflt_en_i(den), .dflt_tgt_i(dtg),
        .valid_o(v0), .dec_err_o(e0), .tgt_o(t0));

    adr_range_decoder #(.N_RULES(NR), .ADDR_W(AW), .N_PORTS(NP), .ARCH(PRIO_TREE)) u1 (
        .req_valid_i(req), .addr_i(addr), .rule_lo_i(lo), .rule_hi_i(hi),
        .rule_tgt_i(tg), .dflt_en_i(den), .dflt_tgt_i(dtg),
        .valid_o(v1), .dec_err_o(e1), .tgt_o(t1));

    task automatic clear_all();
        @(negedge clk);
        req = 1'b0; addr = '0; den = 1'b0; dtg = '0;
        for (int i = 0; i < NR; i++) begin
            lo[i] = '0; hi[i] = '0; tg[i] = '0;
        end
    endtask

    task automatic set_rule(input int i, input logic [AW-1:0] l, input logic [AW-1:0] h,
                            input logic [TW-1:0] t);
        lo[i] = l; hi[i] = h; tg[i] = t;
    endtask

    // Drive a request, wait a quarter period, compare both variants.
    task automatic probe(input string tag, input logic r, input logic [AW-1:0] a,
                         input logic ev, input logic ee, input logic [TW-1:0] et);
        @(negedge clk);
        req = r; addr = a;
        #(CLK_PERIOD/4);
        checks++;
        if ({v0, e0, t0} !== {ev, ee, et}) begin
            errors++;
            $display("FAIL %s linear addr=%h: got v=%b e=%b t=%0d, want v=%b e=%b t=%0d",
                     tag, a, v0, e0, t0, ev, ee, et);
        end
        checks++;
        if ({v1, e1, t1} !== {ev, ee, et}) begin
            errors++;
            $display("FAIL R10 %s tree addr=%h: got v=%b e=%b t=%0d, want v=%b e=%b t=%0d",
                     tag, a, v1, e1, t1, ev, ee, et);
        end
    endtask

    task automatic t_reset();
        // R8 reset state: no request
        probe("R8 reset", 1'b0, 16'h0000, 1'b0, 1'b0, 3'd0);
    endtask

    task automatic t_bounds();
        clear_all();
        set_rule(0, 16'h0100, 16'h0200, 3'd2);
        probe("R1 lower edge", 1'b1, 16'h0100, 1'b1, 1'b0, 3'd2);
        probe("R1 below lower", 1'b1, 16'h00FF, 1'b0, 1'b1, 3'd0);
        probe("R2 below upper", 1'b1, 16'h01FF, 1'b1, 1'b0, 3'd2);
        probe("R2 R7 at upper", 1'b1, 16'h0200, 1'b0, 1'b1, 3'd0);
    endtask

    task automatic t_empty();
        clear_all();
        set_rule(1, 16'h0300, 16'h0300, 3'd3);
        probe("R3 empty entry", 1'b1, 16'h0300, 1'b0, 1'b1, 3'd0);
    endtask

    task automatic t_overlap();
        clear_all();
        set_rule(0, 16'h1000, 16'h2000, 3'd1);
        set_rule(2, 16'h1000, 16'h3000, 3'd3);
        set_rule(3, 16'h1800, 16'h1900, 3'd4);
        probe("R4 three overlap", 1'b1, 16'h1850, 1'b1, 1'b0, 3'd4);
        probe("R4 two overlap", 1'b1, 16'h1900, 1'b1, 1'b0, 3'd3);
        probe("R4 single", 1'b1, 16'h2800, 1'b1, 1'b0, 3'd3);
        set_rule(4, 16'h0000, 16'hFFFF, 3'd0);
        probe("R4 top entry covers", 1'b1, 16'h1850, 1'b1, 1'b0, 3'd0);
    endtask

    task automatic t_shared();
        clear_all();
        set_rule(1, 16'h0010, 16'h0020, 3'd2);
        set_rule(4, 16'h0040, 16'h0050, 3'd2);
        probe("R5 first of shared", 1'b1, 16'h0015, 1'b1, 1'b0, 3'd2);
        probe("R5 second of shared", 1'b1, 16'h0045, 1'b1, 1'b0, 3'd2);
        probe("R5 gap", 1'b1, 16'h0030, 1'b0, 1'b1, 3'd0);
    endtask

    task automatic t_default();
        clear_all();
        den = 1'b1; dtg = 3'd4;
        set_rule(0, 16'h0100, 16'h0200, 3'd1);
        probe("R6 R9 miss to fallback", 1'b1, 16'h0500, 1'b1, 1'b0, 3'd4);
        probe("R11 hit beats fallback", 1'b1, 16'h0150, 1'b1, 1'b0, 3'd1);
        set_rule(2, 16'h0000, 16'hFFFF, 3'd3);
        probe("R2 max address excluded", 1'b1, 16'hFFFF, 1'b1, 1'b0, 3'd4);
        probe("R2 max minus one", 1'b1, 16'hFFFE, 1'b1, 1'b0, 3'd3);
    endtask

    task automatic t_noreq();
        clear_all();
        set_rule(0, 16'h0100, 16'h0200, 3'd2);
        probe("R8 idle on hit", 1'b0, 16'h0150, 1'b0, 1'b0, 3'd0);
        probe("R8 idle on miss", 1'b0, 16'h0900, 1'b0, 1'b0, 3'd0);
        den = 1'b1; dtg = 3'd3;
        probe("R8 idle with fallback", 1'b0, 16'h0900, 1'b0, 1'b0, 3'd0);
    endtask

    initial begin
        req = 1'b0; addr = '0; den = 1'b0; dtg = '0;
        for (int i = 0; i < NR; i++) begin
            lo[i] = '0; hi[i] = '0; tg[i] = '0;
        end
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_bounds();
        t_empty();
        t_overlap();
        t_shared();
        t_default();
        t_noreq();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule